// File: doc/BRIEF.md
# Stack Pointer Bounds Checker

This block watches the stack pointer of a processor core and compares it against a programmable lower and upper bound. A stack pointer value below the lower bound is an underflow event. A value above the upper bound is an overflow event. The two events are tracked separately. Each one has its own monitor-enable bit, a sticky status bit, an interrupt-enable bit and a write-one-to-clear bit. The stack pointer and program counter arrive on input buses qualified by a valid strobe. Software uses a small word-wide register port with a combinational read path. The interrupt line stays high while any enabled status bit is set.

All four per-event registers share one bit layout: underflow sits at bit 8 and overflow at bit 9. This leaves the low bits free for neighbouring monitors that use the same layout. The program counter of the first violating access is latched. A small two-state machine decides when a capture is allowed:
- ST_ARMED: no status bit is set, and a capture may happen.
- ST_LATCHED: at least one status bit is set, and the latched value is frozen.

The machine takes transition T_TRIP (ST_ARMED to ST_LATCHED) on any enabled violation. It takes transition T_REARM (ST_LATCHED to ST_ARMED) once every status bit has been cleared and no new violation sets one in the same cycle.

Top module: `sp_bounds_checker`

## Requirements
- R1: After reset, the enable, status, interrupt-enable and latched-PC registers read 0, the lower bound reads 0, the upper bound reads 0xFFFFFFFF and `irq` is low. With both monitors enabled and the reset bounds, no stack pointer value raises a status bit.
- R2: On a clock edge where `sp_valid` is high, enable bit 8 is set and `sp_value` is below the lower bound (unsigned), status bit 8 is set. It is readable from the next cycle. A value equal to the bound does not set it.
- R3: On a clock edge where `sp_valid` is high, enable bit 9 is set and `sp_value` is above the upper bound (unsigned), status bit 9 is set. It is readable from the next cycle. A value equal to the bound does not set it.
- R4: A stack pointer sample has no effect on status or the latched PC when `sp_valid` is low or the matching enable bit is clear.
- R5: A status bit stays set until a write to the clear register (address 3) has a 1 in that bit position. Writing 0 there, or clearing the other bit, leaves it set. The clear register reads 0.
- R6: When a violation and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R7: The PC register (address 6) takes `pc_value` on a violation only when no status bit was set before that edge. Later violations leave it unchanged until all status bits have been cleared.
- R8: `irq` is high exactly while (status AND interrupt-enable) is nonzero, with the interrupt-enable register at address 2.
- R9: Only bits 8 and 9 are implemented in the enable, interrupt-enable and status registers, and other bits read 0. The status register (address 1) ignores writes.
- R10: The register map is: 0 enable, 1 status, 2 interrupt-enable, 3 clear, 4 lower bound, 5 upper bound, 6 latched PC. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| sp_valid | input | 1 | Qualifies `sp_value` and `pc_value` this cycle |
| sp_value | input | 32 | Current stack pointer |
| pc_value | input | 32 | Program counter of the current access |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted status flop shows up at `irq` and at the status read in the cycle after the edge that corrupted it. It is not masked by later samples, because the bit is sticky. A capture-state machine stuck in ST_LATCHED freezes the PC register: the next violation after a full clear fails to update it, one cycle after that violation. A machine stuck in ST_ARMED overwrites the PC on the second violation. The bench sweeps enable settings, the strobe, and stack pointer values on and around both bounds, then reads status and PC after each sample.

// File: rtl/sp_mon_pkg.sv
package sp_mon_pkg;

    // Word address of each register on the register port.
    typedef enum logic [2:0] {
        SEL_ENABLE = 3'd0,
        SEL_STATUS = 3'd1,
        SEL_IRQEN  = 3'd2,
        SEL_CLEAR  = 3'd3,
        SEL_LOWER  = 3'd4,
        SEL_UPPER  = 3'd5,
        SEL_PC     = 3'd6
    } reg_sel_e;

    // PC capture permission.
    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_LATCHED = 1'b1
    } mon_state_e;

    // Event positions shared with neighbouring monitors.
    localparam int unsigned UNDER_POS = 8;
    localparam int unsigned OVER_POS  = 9;

endpackage

// File: rtl/sp_mon_regs.sv
module sp_mon_regs
    import sp_mon_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned AW        = 3,
    parameter int unsigned UNDER_BIT = UNDER_POS,
    parameter int unsigned OVER_BIT  = OVER_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] stat_i,
    input  logic [DATA_W-1:0] pc_i,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] ie_q,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q,
    output logic [DATA_W-1:0] clr_pulse
);

    localparam logic [DATA_W-1:0] EVT_MASK =
        (DATA_W'(1) << UNDER_BIT) | (DATA_W'(1) << OVER_BIT);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    // Configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            ie_q <= '0;
            lo_q <= '0;
            hi_q <= '1;
        end else if (reg_we) begin
            unique case (sel)
                SEL_ENABLE: en_q <= reg_wdata & EVT_MASK;
                SEL_IRQEN:  ie_q <= reg_wdata & EVT_MASK;
                SEL_LOWER:  lo_q <= reg_wdata;
                SEL_UPPER:  hi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // One-cycle clear request, never stored
    always_comb begin
        clr_pulse = '0;
        if (reg_we && sel == SEL_CLEAR) begin
            clr_pulse = reg_wdata & EVT_MASK;
        end
    end

    // Read path
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_ENABLE: reg_rdata = en_q;
            SEL_STATUS: reg_rdata = stat_i;
            SEL_IRQEN:  reg_rdata = ie_q;
            SEL_CLEAR:  reg_rdata = '0;
            SEL_LOWER:  reg_rdata = lo_q;
            SEL_UPPER:  reg_rdata = hi_q;
            SEL_PC:     reg_rdata = pc_i;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sp_mon_detect.sv
module sp_mon_detect #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned UNDER_BIT = 8,
    parameter int unsigned OVER_BIT  = 9
) (
    input  logic              sp_valid,
    input  logic [DATA_W-1:0] sp_value,
    input  logic              en_under,
    input  logic              en_over,
    input  logic [DATA_W-1:0] lo_bound,
    input  logic [DATA_W-1:0] hi_bound,
    output logic [DATA_W-1:0] hit
);

    logic below_lo;
    logic above_hi;

    // Unsigned compares
    assign below_lo = sp_value < lo_bound;
    assign above_hi = sp_value > hi_bound;

    always_comb begin
        hit = '0;
        hit[UNDER_BIT] = sp_valid && en_under && below_lo;
        hit[OVER_BIT]  = sp_valid && en_over  && above_hi;
    end

endmodule

// File: rtl/sp_mon_status.sv
module sp_mon_status
    import sp_mon_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] hit,
    input  logic [DATA_W-1:0] clr,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] stat_q,
    output logic [DATA_W-1:0] pc_q
);

    mon_state_e  state;
    mon_state_e  state_n;
    logic        capture;
    logic [DATA_W-1:0] stat_n;

    // Set has priority over clear
    assign stat_n = (stat_q & ~clr) | hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= state_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_ARMED:   if (|hit)           state_n = ST_LATCHED; // T_TRIP
            ST_LATCHED: if (stat_n == '0)   state_n = ST_ARMED;   // T_REARM
            default:                        state_n = ST_ARMED;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        capture = 1'b0;
        unique case (state)
            ST_ARMED:   capture = |hit;
            ST_LATCHED: capture = 1'b0;
            default:    capture = 1'b0;
        endcase
    end

    // Status and captured PC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            pc_q   <= '0;
        end else begin
            stat_q <= stat_n;
            if (capture) begin
                pc_q <= pc_in;
            end
        end
    end

endmodule

// File: rtl/sp_bounds_checker.sv
module sp_bounds_checker
    import sp_mon_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned AW        = 3,
    parameter int unsigned UNDER_BIT = UNDER_POS,
    parameter int unsigned OVER_BIT  = OVER_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sp_valid,
    input  logic [DATA_W-1:0] sp_value,
    input  logic [DATA_W-1:0] pc_value,
    output logic              irq
);

    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] ie_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] clr_pulse;
    logic [DATA_W-1:0] hit;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] pc_q;

    sp_mon_regs #(
        .DATA_W(DATA_W), .AW(AW), .UNDER_BIT(UNDER_BIT), .OVER_BIT(OVER_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .stat_i(stat_q), .pc_i(pc_q),
        .en_q(en_q), .ie_q(ie_q), .lo_q(lo_q), .hi_q(hi_q),
        .clr_pulse(clr_pulse)
    );

    sp_mon_detect #(
        .DATA_W(DATA_W), .UNDER_BIT(UNDER_BIT), .OVER_BIT(OVER_BIT)
    ) u_detect (
        .sp_valid(sp_valid), .sp_value(sp_value),
        .en_under(en_q[UNDER_BIT]), .en_over(en_q[OVER_BIT]),
        .lo_bound(lo_q), .hi_bound(hi_q),
        .hit(hit)
    );

    sp_mon_status #(
        .DATA_W(DATA_W)
    ) u_status (
        .clk(clk), .rst_n(rst_n),
        .hit(hit), .clr(clr_pulse), .pc_in(pc_value),
        .stat_q(stat_q), .pc_q(pc_q)
    );

    assign irq = |(stat_q & ie_q);

endmodule

// File: rtl/sp_bounds_checker_chk.sv
module sp_bounds_checker_chk
    import sp_mon_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [AW-1:0]     reg_addr,
    input logic              sp_valid,
    input logic [DATA_W-1:0] sp_value,
    input logic              irq,
    input logic              en_under,
    input logic              en_over,
    input logic [DATA_W-1:0] lo_q,
    input logic [DATA_W-1:0] hi_q,
    input logic              hit_under,
    input logic              clr_under,
    input logic              st_under,
    input logic              st_over,
    input logic [DATA_W-1:0] pc_q
);

    // R2: underflow status rises only after a qualified low sample
    p_under_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_under) |-> $past(sp_valid && en_under && (sp_value < lo_q)));

    // R3: overflow status rises only after a qualified high sample
    p_over_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_over) |-> $past(sp_valid && en_over && (sp_value > hi_q)));

    // R5: status holds without a clear request
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_under && !clr_under) |=> st_under);

    // R6: a violation wins over a simultaneous clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_under |=> st_under);

    // R7: captured PC frozen while any status bit is set
    p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_under || st_over) |=> $stable(pc_q));

    // R8: interrupt drops only after a clear or interrupt-enable write
    p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_we &&
            (reg_addr == AW'(SEL_CLEAR) || reg_addr == AW'(SEL_IRQEN))));

endmodule

bind sp_bounds_checker sp_bounds_checker_chk #(
    .DATA_W(DATA_W), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr),
    .sp_valid(sp_valid), .sp_value(sp_value),
    .irq(irq),
    .en_under(en_q[UNDER_BIT]), .en_over(en_q[OVER_BIT]),
    .lo_q(lo_q), .hi_q(hi_q),
    .hit_under(hit[UNDER_BIT]), .clr_under(clr_pulse[UNDER_BIT]),
    .st_under(stat_q[UNDER_BIT]), .st_over(stat_q[OVER_BIT]),
    .pc_q(pc_q)
);

// File: tb/test_sp_bounds_checker.sv
module test_sp_bounds_checker;

    localparam logic [2:0] A_EN = 3'd0, A_ST = 3'd1, A_IE = 3'd2, A_CLR = 3'd3,
                           A_LO = 3'd4, A_HI = 3'd5, A_PC = 3'd6;
    localparam logic [31:0] BU = 32'h100;  // bit 8
    localparam logic [31:0] BO = 32'h200;  // bit 9
    localparam logic [31:0] LOB = 32'h100;
    localparam logic [31:0] HIB = 32'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sp_valid = 1'b0;
    logic [31:0] sp_value = '0;
    logic [31:0] pc_value = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sp_bounds_checker i_sp_bounds_checker (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .sp_valid(sp_valid), .sp_value(sp_value), .pc_value(pc_value),
        .irq(irq)
    );

    function automatic logic [31:0] sp_pick(input int k);
        case (k)
            0: return 32'h0;
            1: return LOB - 1;
            2: return LOB;
            3: return 32'h150;
            4: return HIB;
            5: return HIB + 1;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic samp(input logic v, input logic [31:0] sp, input logic [31:0] pc);
        sp_valid = v; sp_value = sp; pc_value = pc;
        @(negedge clk);
        sp_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(A_EN, d); check("R1 enable", d, 32'h0);
        rd(A_ST, d); check("R1 status", d, 32'h0);
        rd(A_IE, d); check("R1 irq-enable", d, 32'h0);
        rd(A_LO, d); check("R1 lower", d, 32'h0);
        rd(A_HI, d); check("R1 upper", d, 32'hFFFF_FFFF);
        rd(A_PC, d); check("R1 pc", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R1 reset bounds cannot trip
        wr(A_EN, BU | BO);
        for (int k = 0; k < 7; k++) begin
            samp(1'b1, sp_pick(k), 32'h9000);
            rd(A_ST, d); check("R1 no trip at reset bounds", d, 32'h0);
        end

        // R9 implemented bits, read-only status
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d); check("R9 enable mask", d, BU | BO);
        wr(A_IE, 32'hFFFF_FFFF);
        rd(A_IE, d); check("R9 irq-enable mask", d, BU | BO);
        wr(A_ST, BU | BO);
        rd(A_ST, d); check("R9 status write ignored", d, 32'h0);
        check("R9 irq after status write", {31'b0, irq}, 32'h0);
        wr(A_IE, 32'h0);

        // R10 map
        wr(A_LO, LOB); wr(A_HI, HIB);
        rd(A_LO, d); check("R10 lower", d, LOB);
        rd(A_HI, d); check("R10 upper", d, HIB);
        rd(A_CLR, d); check("R10 clear reads 0", d, 32'h0);
        rd(3'd7, d); check("R10 unused address", d, 32'h0);

        // R2/R3/R4 sweep over enables, strobe and values
        exp_pc = 32'h0;
        for (int en = 0; en < 4; en++) begin
            wr(A_EN, 32'(en) << 8);
            for (int v = 0; v < 2; v++) begin
                for (int k = 0; k < 7; k++) begin
                    logic [31:0] sp, pc, es;
                    sp = sp_pick(k);
                    pc = 32'h4000 + 32'((en * 14 + v * 7 + k) * 4);
                    es = 32'h0;
                    if (v == 1 && en[0] && sp < LOB) es |= BU;
                    if (v == 1 && en[1] && sp > HIB) es |= BO;
                    wr(A_CLR, BU | BO);
                    samp(v[0], sp, pc);
                    if (es != 0) exp_pc = pc;
                    rd(A_ST, d); check("R2/R3/R4 status", d, es);
                    rd(A_PC, d); check("R4/R7 pc", d, exp_pc);
                end
            end
        end

        // R5 sticky status
        wr(A_EN, BU | BO);
        wr(A_CLR, BU | BO);
        samp(1'b1, 32'h10, 32'h5000);
        repeat (4) @(negedge clk);
        rd(A_ST, d); check("R5 held", d, BU);
        wr(A_CLR, BO);
        rd(A_ST, d); check("R5 other clear", d, BU);
        wr(A_CLR, 32'h0);
        rd(A_ST, d); check("R5 zero clear", d, BU);
        wr(A_CLR, BU);
        rd(A_ST, d); check("R5 cleared", d, 32'h0);

        // R6 set beats clear
        samp(1'b1, 32'h10, 32'h5100);
        sp_valid = 1'b1; sp_value = 32'h10;
        reg_we = 1'b1; reg_addr = A_CLR; reg_wdata = BU;
        @(negedge clk);
        sp_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        rd(A_ST, d); check("R6 same-cycle set", d, BU);
        sp_valid = 1'b1; sp_value = 32'h300;
        reg_we = 1'b1; reg_addr = A_CLR; reg_wdata = BU;
        @(negedge clk);
        sp_valid = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        rd(A_ST, d); check("R6 clear with other set", d, BO);

        // R7 first-violation capture
        wr(A_CLR, BU | BO);
        samp(1'b1, 32'h10, 32'hAAA0);
        rd(A_PC, d); check("R7 first capture", d, 32'hAAA0);
        samp(1'b1, 32'h300, 32'hBBB0);
        rd(A_ST, d); check("R7 both set", d, BU | BO);
        rd(A_PC, d); check("R7 second ignored", d, 32'hAAA0);
        wr(A_CLR, BU);
        samp(1'b1, 32'h10, 32'hCCC0);
        rd(A_PC, d); check("R7 partial clear keeps pc", d, 32'hAAA0);
        wr(A_CLR, BU | BO);
        samp(1'b1, 32'h300, 32'hDDD0);
        rd(A_PC, d); check("R7 recapture", d, 32'hDDD0);

        // R8 interrupt combinations
        for (int st = 0; st < 4; st++) begin
            for (int ie = 0; ie < 4; ie++) begin
                wr(A_CLR, BU | BO);
                wr(A_IE, 32'(ie) << 8);
                if (st[0]) samp(1'b1, 32'h10, 32'h0);
                if (st[1]) samp(1'b1, 32'h300, 32'h0);
                #1;
                check("R8 irq", {31'b0, irq}, {31'b0, |(st & ie)});
            end
        end

        finish_run();
    end

endmodule